// File: doc/BRIEF.md
# DDR3 Mode Register Initialisation Sequencer

This block performs the mode-register phase of DDR3 power-up for one or two chip selects. A one-cycle start pulse begins the run. For each chip select, beginning with index 0, the block emits five 32-bit command words on a valid/ready port. Four of these are load-mode writes and the last is a long ZQ calibration. The command words are built from a small set of configuration fields: CAS latency, write recovery, CAS write latency, the two termination codes, the self-refresh temperature bit and the fast-exit enable.

The block samples the configuration and the chip-select count on the cycle it accepts start. Later changes on those inputs do not affect a run already in progress. While the run is active the busy flag stays high. A done pulse marks the end of the run. A downstream command engine consumes the words and turns them into DRAM bus cycles.

Top module: `ddr3_mrs_seq`

## Requirements
- R1: After reset, `busy_o`, `cmd_valid_o` and `done_o` are all 0.
- R2: Every command word has this layout:
  - payload in bits 31:16;
  - a request flag fixed at 1 in bit 15;
  - zeros in bits 14:7;
  - a 3-bit command code in bits 6:4;
  - the chip-select index in bit 3;
  - the bank / mode-register number in bits 2:0.
- R3: For each chip select the five words appear in this order:
  - mode register 2 (bank 2), then mode register 3 (bank 3), then mode register 1 (bank 1), then mode register 0 (bank 0), all with command code 3;
  - then a ZQ calibration word with command code 4, bank 0 and payload 0x0400.
- R4: The mode register 2 payload is built as follows:
  - bits 10:9 carry `rtt_wr_i`;
  - bit 7 carries `srt_i`;
  - bits 4:3 carry the low 2 bits of (`cwl_i` − 3);
  - all other payload bits are 0.
- R5: The mode register 3 payload is zero.
- R6: The mode register 1 payload has bit 2 = `rtt_nom_i[0]` and bit 6 = `rtt_nom_i[1]`; all other payload bits are 0.
- R7: The mode register 0 payload is built as follows:
  - bits 6:4 carry the low 3 bits of (`cl_i` − 1);
  - bit 8 (DLL reset) is 1;
  - bits 11:9 carry the low 3 bits of (`wr_i` − 3);
  - bit 12 carries `fast_exit_i`;
  - all other payload bits are 0.
- R8: While `cmd_valid_o` is 1 and `cmd_ready_i` is 0, the same word stays on `cmd_word_o` and valid stays high. A word counts as accepted only on a cycle where valid and ready are both 1.
- R9: A start pulse that arrives while `busy_o` is 1 is ignored; the run continues unchanged and emits no extra words.
- R10: `done_o` is high for exactly one cycle, the cycle right after the last ZQ word is accepted. In that cycle `busy_o` is already 0.
- R11: The chip-select count is interpreted as follows:
  - a value of 2 runs chip select 0 and then chip select 1; chip select 1's first word follows acceptance of chip select 0's ZQ word;
  - any other value runs chip select 0 only.
- R12: Configuration and chip-select count are captured when start is accepted; input changes while busy do not alter the words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| cs_count_i | input | 2 | Number of chip selects (1 or 2) |
| cl_i | input | 4 | CAS latency register value |
| wr_i | input | 4 | Write recovery value |
| cwl_i | input | 3 | CAS write latency |
| rtt_nom_i | input | 2 | Nominal termination code |
| rtt_wr_i | input | 2 | Dynamic write termination code |
| srt_i | input | 1 | Self-refresh temperature range bit |
| fast_exit_i | input | 1 | Precharge power-down fast-exit enable |
| cmd_valid_o | output | 1 | Command word valid |
| cmd_ready_i | input | 1 | Command word accepted when high with valid |
| cmd_word_o | output | 32 | Packed command word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Faults in the internal state show up quickly at the port.

- A wrong step index appears as a wrong bank number or payload on the very next presented word.
- A wrong chip-select counter shows in bit 3 of the word, or as a missing or extra set of five words.
- A fault in the acceptance logic shows as a word that changes while ready is held low, which the bench sees within one cycle.
- Completion errors show as a done pulse that is missing, early or two cycles long. The bench checks that pulse in the cycle right after the final acceptance.

// File: rtl/ddr3_mrs_pkg.sv
package ddr3_mrs_pkg;

  typedef enum logic [2:0] {
    STEP_MR2 = 3'd0,
    STEP_MR3 = 3'd1,
    STEP_MR1 = 3'd2,
    STEP_MR0 = 3'd3,
    STEP_ZQ  = 3'd4
  } step_e;

  typedef struct packed {
    logic [3:0] cl;
    logic [3:0] wr;
    logic [2:0] cwl;
    logic [1:0] rtt_nom;
    logic [1:0] rtt_wr;
    logic       srt;
    logic       fast_exit;
  } mrs_cfg_t;

  localparam logic [2:0] CMD_LOAD_MODE = 3'd3;
  localparam logic [2:0] CMD_ZQ_LONG   = 3'd4;

  function automatic logic [15:0] mr2_payload(input mrs_cfg_t c);
    logic [2:0] cwl_off;
    cwl_off = c.cwl - 3'd3;
    mr2_payload = '0;
    mr2_payload[10:9] = c.rtt_wr;
    mr2_payload[7]    = c.srt;
    mr2_payload[4:3]  = cwl_off[1:0];
  endfunction

  function automatic logic [15:0] mr1_payload(input mrs_cfg_t c);
    mr1_payload = '0;
    mr1_payload[2] = c.rtt_nom[0];
    mr1_payload[6] = c.rtt_nom[1];
  endfunction

  function automatic logic [15:0] mr0_payload(input mrs_cfg_t c);
    logic [3:0] cl_off;
    logic [3:0] wr_off;
    cl_off = c.cl - 4'd1;
    wr_off = c.wr - 4'd3;
    mr0_payload = '0;
    mr0_payload[6:4]  = cl_off[2:0];
    mr0_payload[8]    = 1'b1;
    mr0_payload[11:9] = wr_off[2:0];
    mr0_payload[12]   = c.fast_exit;
  endfunction

  function automatic logic [15:0] zq_payload();
    zq_payload = 16'h0400;
  endfunction

  function automatic logic [2:0] bank_of(input step_e s);
    case (s)
      STEP_MR2: bank_of = 3'd2;
      STEP_MR3: bank_of = 3'd3;
      STEP_MR1: bank_of = 3'd1;
      default:  bank_of = 3'd0;
    endcase
  endfunction

  function automatic logic [31:0] pack_word(input logic [15:0] payload,
                                            input logic [2:0]  cmd,
                                            input logic        cs,
                                            input logic [2:0]  bank);
    pack_word = {payload, 1'b1, 8'h00, cmd, cs, bank};
  endfunction

endpackage

// File: rtl/mrs_step_ctrl.sv
module mrs_step_ctrl
  import ddr3_mrs_pkg::*;
#(
  parameter int MAX_CS = 2,
  localparam int CS_IDX_W = (MAX_CS > 1) ? $clog2(MAX_CS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [CS_IDX_W-1:0] last_cs_i,
  input  logic                accept_i,
  output logic                busy_o,
  output logic                launch_o,
  output step_e               step_o,
  output logic [CS_IDX_W-1:0] cs_o,
  output logic [CS_IDX_W-1:0] last_cs_o,
  output logic                last_cmd_o,
  output logic                done_o
);

  logic                busy_q;
  logic                done_q;
  step_e               step_q;
  logic [CS_IDX_W-1:0] cs_q;
  logic [CS_IDX_W-1:0] last_cs_q;

  assign launch_o   = start_i && !busy_q;
  assign last_cmd_o = busy_q && (step_q == STEP_ZQ) && (cs_q == last_cs_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      step_q    <= STEP_MR2;
      cs_q      <= '0;
      last_cs_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (launch_o) begin
        busy_q    <= 1'b1;
        step_q    <= STEP_MR2;
        cs_q      <= '0;
        last_cs_q <= last_cs_i;
      end else if (busy_q && accept_i) begin
        if (step_q == STEP_ZQ) begin
          step_q <= STEP_MR2;
          if (cs_q == last_cs_q) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            cs_q <= cs_q + 1'b1;
          end
        end else begin
          step_q <= step_e'(step_q + 3'd1);
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign step_o    = step_q;
  assign cs_o      = cs_q;
  assign last_cs_o = last_cs_q;

endmodule

// File: rtl/mrs_word_pack.sv
module mrs_word_pack
  import ddr3_mrs_pkg::*;
#(
  parameter int CS_IDX_W = 1
) (
  input  step_e               step_i,
  input  logic [CS_IDX_W-1:0] cs_i,
  input  mrs_cfg_t            cfg_i,
  output logic [31:0]         word_o
);

  logic [15:0] payload;
  logic [2:0]  cmd;

  always_comb begin
    cmd = CMD_LOAD_MODE;
    case (step_i)
      STEP_MR2: payload = mr2_payload(cfg_i);
      STEP_MR1: payload = mr1_payload(cfg_i);
      STEP_MR0: payload = mr0_payload(cfg_i);
      STEP_ZQ: begin
        payload = zq_payload();
        cmd     = CMD_ZQ_LONG;
      end
      default:  payload = 16'h0000;
    endcase
  end

  assign word_o = pack_word(payload, cmd, cs_i[0], bank_of(step_i));

endmodule

// File: rtl/ddr3_mrs_seq.sv
module ddr3_mrs_seq
  import ddr3_mrs_pkg::*;
#(
  parameter int MAX_CS = 2,
  localparam int CS_IDX_W = (MAX_CS > 1) ? $clog2(MAX_CS) : 1,
  localparam int CNT_W    = CS_IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cs_count_i,
  input  logic [3:0]       cl_i,
  input  logic [3:0]       wr_i,
  input  logic [2:0]       cwl_i,
  input  logic [1:0]       rtt_nom_i,
  input  logic [1:0]       rtt_wr_i,
  input  logic             srt_i,
  input  logic             fast_exit_i,
  output logic             cmd_valid_o,
  input  logic             cmd_ready_i,
  output logic [31:0]      cmd_word_o,
  output logic             busy_o,
  output logic             done_o
);

  mrs_cfg_t            cfg_in;
  mrs_cfg_t            cfg_q;
  logic                launch_w;
  logic                accept_w;
  logic                last_cmd_w;
  logic                multi_cs_w;
  step_e               step_w;
  logic [CS_IDX_W-1:0] cs_w;
  logic [CS_IDX_W-1:0] last_cs_req;
  logic [CS_IDX_W-1:0] last_cs_w;

  assign cfg_in = '{cl: cl_i, wr: wr_i, cwl: cwl_i, rtt_nom: rtt_nom_i,
                    rtt_wr: rtt_wr_i, srt: srt_i, fast_exit: fast_exit_i};

  always_comb begin
    if (cs_count_i >= CNT_W'(2) && cs_count_i <= CNT_W'(MAX_CS))
      last_cs_req = CS_IDX_W'(cs_count_i - CNT_W'(1));
    else
      last_cs_req = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (launch_w) cfg_q <= cfg_in;
  end

  mrs_step_ctrl #(.MAX_CS(MAX_CS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .last_cs_i  (last_cs_req),
    .accept_i   (accept_w),
    .busy_o     (busy_o),
    .launch_o   (launch_w),
    .step_o     (step_w),
    .cs_o       (cs_w),
    .last_cs_o  (last_cs_w),
    .last_cmd_o (last_cmd_w),
    .done_o     (done_o)
  );

  mrs_word_pack #(.CS_IDX_W(CS_IDX_W)) u_pack (
    .step_i (step_w),
    .cs_i   (cs_w),
    .cfg_i  (cfg_q),
    .word_o (cmd_word_o)
  );

  assign cmd_valid_o = busy_o;
  assign accept_w    = cmd_valid_o && cmd_ready_i;
  assign multi_cs_w  = (last_cs_w != '0);

endmodule

// File: rtl/ddr3_mrs_seq_chk.sv
module ddr3_mrs_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        cmd_valid_o,
  input logic        cmd_ready_i,
  input logic [31:0] cmd_word_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        accept_w,
  input logic        last_cmd_w,
  input logic        multi_cs_w
);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_word_o));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w && last_cmd_w |=> done_o && !busy_o);

  assert_word_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> cmd_word_o[15] && (cmd_word_o[14:7] == 8'h00));

  assert_zq_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && (cmd_word_o[6:4] == 3'd4) |->
      (cmd_word_o[31:16] == 16'h0400) && (cmd_word_o[2:0] == 3'd0));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i && !accept_w |=> busy_o && $stable(cmd_word_o));

  assert_cs1_only_multi_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && cmd_word_o[3] |-> multi_cs_w);

endmodule

bind ddr3_mrs_seq ddr3_mrs_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .cmd_valid_o (cmd_valid_o),
  .cmd_ready_i (cmd_ready_i),
  .cmd_word_o  (cmd_word_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .accept_w    (accept_w),
  .last_cmd_w  (last_cmd_w),
  .multi_cs_w  (multi_cs_w)
);

// File: tb/tb_ddr3_mrs_seq.sv
module tb_ddr3_mrs_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  cs_count_i = 2'd1;
  logic [3:0]  cl_i = 4'd0;
  logic [3:0]  wr_i = 4'd0;
  logic [2:0]  cwl_i = 3'd0;
  logic [1:0]  rtt_nom_i = 2'd0;
  logic [1:0]  rtt_wr_i = 2'd0;
  logic        srt_i = 1'b0;
  logic        fast_exit_i = 1'b0;
  logic        cmd_valid_o;
  logic        cmd_ready_i = 1'b0;
  logic [31:0] cmd_word_o;
  logic        busy_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr3_mrs_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cs_count_i(cs_count_i),
    .cl_i(cl_i), .wr_i(wr_i), .cwl_i(cwl_i), .rtt_nom_i(rtt_nom_i),
    .rtt_wr_i(rtt_wr_i), .srt_i(srt_i), .fast_exit_i(fast_exit_i),
    .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
    .cmd_word_o(cmd_word_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Expected word from the requirements, written as arithmetic
  function automatic longint exp_word(input int cs, input int step, input int cl, input int wr,
                                      input int cwl, input int rn, input int rw, input int srt,
                                      input int fe);
    int payload, cmd, bank;
    cmd = 3;
    case (step)
      0: begin bank = 2; payload = rw * 512 + srt * 128 + ((cwl + 5) % 4) * 8; end
      1: begin bank = 3; payload = 0; end
      2: begin bank = 1; payload = (rn % 2) * 4 + (rn / 2) * 64; end
      3: begin bank = 0; payload = ((cl + 15) % 8) * 16 + 256 + ((wr + 13) % 8) * 512 + fe * 4096; end
      default: begin bank = 0; payload = 1024; cmd = 4; end
    endcase
    exp_word = longint'(payload) * 65536 + 32768 + cmd * 16 + cs * 8 + bank;
  endfunction

  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // mode: 0 ready always, 1 alternate, 2 one in three
  task automatic run_seq(input int ncs, input int cl, input int wr, input int cwl, input int rn,
                         input int rw, input int srt, input int fe, input int mode,
                         input bit disturb, input string tag);
    int nexp, got, iter;
    bit prev_stall;
    logic [31:0] prev_word;
    cs_count_i = 2'(ncs); cl_i = 4'(cl); wr_i = 4'(wr); cwl_i = 3'(cwl);
    rtt_nom_i = 2'(rn); rtt_wr_i = 2'(rw); srt_i = 1'(srt); fast_exit_i = 1'(fe);
    nexp = (ncs == 2) ? 10 : 5;
    got = 0; iter = 0; prev_stall = 0; prev_word = '0;
    pulse_start();
    check(busy_o === 1'b1, {tag, " busy after start"}, busy_o, 1);
    // R12: inputs changed while busy must not alter words
    cs_count_i = (ncs == 2) ? 2'd1 : 2'd2;
    cl_i = ~cl_i; wr_i = ~wr_i; cwl_i = ~cwl_i; rtt_nom_i = ~rtt_nom_i;
    rtt_wr_i = ~rtt_wr_i; srt_i = ~srt_i; fast_exit_i = ~fast_exit_i;
    while (got < nexp && iter < 200) begin
      iter++;
      case (mode)
        0: cmd_ready_i = 1'b1;
        1: cmd_ready_i = iter[0];
        default: cmd_ready_i = (iter % 3 == 0);
      endcase
      // R9: a start pulse during the run
      start_i = disturb && (iter == 4 || iter == 9);
      if (prev_stall) begin
        check(cmd_valid_o === 1'b1 && cmd_word_o === prev_word, {tag, " R8 hold"},
              cmd_word_o, prev_word);
      end
      if (cmd_valid_o && cmd_ready_i) begin
        longint e;
        e = exp_word(got / 5, got % 5, cl, wr, cwl, rn, rw, srt, fe);
        check(cmd_word_o === 32'(e), {tag, " R2 R3 R4 R5 R6 R7 R11 R12 word"}, cmd_word_o, e);
        got++;
      end
      prev_stall = cmd_valid_o && !cmd_ready_i;
      prev_word = cmd_word_o;
      @(negedge clk);
    end
    start_i = 1'b0;
    cmd_ready_i = 1'b0;
    check(got == nexp, {tag, " R11 word count"}, got, nexp);
    check(done_o === 1'b1 && busy_o === 1'b0, {tag, " R10 done after last"},
          {done_o, busy_o}, 2'b10);
    @(negedge clk);
    check(done_o === 1'b0, {tag, " R10 done one cycle"}, done_o, 0);
    check(cmd_valid_o === 1'b0, {tag, " R9 no extra words"}, cmd_valid_o, 0);
  endtask

  task automatic t_reset();
    check(busy_o === 1'b0, "R1 busy", busy_o, 0);
    check(cmd_valid_o === 1'b0, "R1 valid", cmd_valid_o, 0);
    check(done_o === 1'b0, "R1 done", done_o, 0);
  endtask

  task automatic t_single();
    run_seq(1, 6, 8, 5, 1, 2, 1, 1, 0, 0, "single");
  endtask

  task automatic t_dual();
    run_seq(2, 9, 12, 6, 2, 1, 0, 0, 1, 0, "dual");
  endtask

  task automatic t_busy_start();
    run_seq(2, 5, 5, 3, 3, 3, 1, 0, 2, 1, "busy_start");
  endtask

  task automatic t_bad_count();
    run_seq(3, 7, 10, 4, 0, 0, 0, 1, 1, 0, "count3");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_dual();
    t_busy_start();
    t_bad_count();
    repeat (2) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule